// File: doc/BRIEF.md
# Power-On Strap Sampling Controller

This block manages five pins that serve two roles. Right after the supply becomes good, each pin is an input. An external pull resistor on the pin sets its level. Later the same pin carries a clock output. The controller holds all five output buffers disabled (three-stated) for a timed window, counted in reference-clock cycles. It captures every pin level on the last cycle of that window and then turns the buffers on.

Only a loss of the supply clears the captured values. A loss of the supply also restarts the window, so the pins are sampled afresh. The controller also resolves the 3-bit frequency code. The code comes either from the captured select straps or from register select bits, and a register override bit chooses between them. A build parameter states whether the fast variant is present. Without the fast variant, code 110 is unsupported. The controller replaces it with a safe code and raises a flag.

Top module: `strap_latch_ctrl`

## Requirements
- R1: While `supply_ok` is low at a clock edge, every output is 0 after that edge. This covers `pin_oe`, `straps_valid`, `mode_strap`, `sdram_follow_cpu`, `fs_strap`, `freq_code` and `code_clamped`.
- R2: After `supply_ok` rises, `pin_oe` and `straps_valid` stay 0 through the first WINDOW_CYCLES-1 clock edges sampled with `supply_ok` high.
- R3: On the WINDOW_CYCLES-th such edge, the pin levels are captured and `straps_valid` becomes 1. The pin mapping is: `strap_pins[2:0]` gives `fs_strap[2:0]`, `strap_pins[3]` gives `mode_strap`, and `strap_pins[4]` gives the SDRAM-source strap.
- R4: `pin_oe` goes to all ones one cycle after the capture edge, and it stays all ones while `supply_ok` is high.
- R5: Once captured, the strap values ignore every later change on `strap_pins`.
- R6: Only `supply_ok` going low clears the straps. If the supply drops during a window, the window restarts from zero.
- R7: `freq_code` is registered with one cycle of latency. The source is `reg_sel` when `reg_override` is 1, and `fs_strap` when it is 0.
- R8: `sdram_follow_cpu` equals the captured SDRAM-source strap: 1 means the SDRAM clocks follow the CPU frequency, and 0 means they follow the AGP frequency.
- R9: With HIGH_PERF=0, a resolved code of 3'b110 appears as SAFE_CODE (default 3'b111), and `code_clamped` is 1 in the same cycle. Otherwise `code_clamped` is 0.
- R10: With HIGH_PERF=1, code 3'b110 passes through unchanged and `code_clamped` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| supply_ok | input | 1 | Power-good indication; low acts as synchronous reset |
| strap_pins | input | 5 | Levels on the dual-role pins |
| reg_override | input | 1 | 1 selects the register select bits |
| reg_sel | input | 3 | Register frequency select |
| pin_oe | output | 5 | Output-buffer enables, one per pin |
| straps_valid | output | 1 | Straps captured |
| mode_strap | output | 1 | Captured pin-function mode |
| sdram_follow_cpu | output | 1 | Captured SDRAM clock source |
| fs_strap | output | 3 | Captured frequency-select straps |
| freq_code | output | 3 | Resolved frequency code |
| code_clamped | output | 1 | Unsupported code was replaced |

## Verification
Two events can land on the same edge: the closing of the strap window and a change of the register override with new select bits. The bench provokes this by raising `reg_override` with a new `reg_sel` just before the edge that ends a restarted window. The capture edge must then show the register code, and must not show the freshly latched straps or the reset value. Once the override is dropped, the latched strap code must appear, clamped where the variant requires it.

// File: rtl/strap_pkg.sv
package strap_pkg;
  localparam int NUM_PINS = 5;
  localparam int FS_W     = 3;

  // pin index map inside the strap vector
  localparam int PIN_FS_LO = 0;
  localparam int PIN_MODE  = 3;
  localparam int PIN_SDSEL = 4;

  typedef struct packed {
    logic            sd_sel;
    logic            mode;
    logic [FS_W-1:0] fs;
  } strap_t;

  localparam logic [FS_W-1:0] FAST_ONLY_CODE = 3'b110;
endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer #(
  parameter int WINDOW_CYCLES = 28636
) (
  input  logic clk,
  input  logic supply_ok,
  output logic capture_now,
  output logic window_done
);
  localparam int CNT_W = (WINDOW_CYCLES > 1) ? $clog2(WINDOW_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign capture_now = supply_ok && !window_done && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      cnt         <= '0;
      window_done <= 1'b0;
    end else if (capture_now) begin
      window_done <= 1'b1;
    end else if (!window_done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import strap_pkg::*;
(
  input  logic                clk,
  input  logic                supply_ok,
  input  logic                capture_now,
  input  logic [NUM_PINS-1:0] pins,
  output strap_t              straps
);
  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      straps <= '0;
    end else if (capture_now) begin
      straps.fs     <= pins[PIN_FS_LO +: FS_W];
      straps.mode   <= pins[PIN_MODE];
      straps.sd_sel <= pins[PIN_SDSEL];
    end
  end
endmodule

// File: rtl/freq_code_resolve.sv
module freq_code_resolve
  import strap_pkg::*;
#(
  parameter bit              HIGH_PERF = 1'b0,
  parameter logic [FS_W-1:0] SAFE_CODE = 3'b111
) (
  input  logic            clk,
  input  logic            supply_ok,
  input  logic            use_reg,
  input  logic [FS_W-1:0] reg_code,
  input  logic [FS_W-1:0] strap_code,
  output logic [FS_W-1:0] code,
  output logic            clamped
);
  logic [FS_W-1:0] picked;
  logic [FS_W-1:0] legal;
  logic            bad;

  assign picked = use_reg ? reg_code : strap_code;

  generate
    if (HIGH_PERF) begin : g_fast
      assign bad = 1'b0;
    end else begin : g_std
      assign bad = (picked == FAST_ONLY_CODE);
    end
  endgenerate

  assign legal = bad ? SAFE_CODE : picked;

  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      code    <= '0;
      clamped <= 1'b0;
    end else begin
      code    <= legal;
      clamped <= bad;
    end
  end
endmodule

// File: rtl/strap_latch_ctrl.sv
module strap_latch_ctrl
  import strap_pkg::*;
#(
  parameter int              WINDOW_CYCLES = 28636,
  parameter bit              HIGH_PERF     = 1'b0,
  parameter logic [FS_W-1:0] SAFE_CODE     = 3'b111
) (
  input  logic                clk,
  input  logic                supply_ok,
  input  logic [NUM_PINS-1:0] strap_pins,
  input  logic                reg_override,
  input  logic [FS_W-1:0]     reg_sel,
  output logic [NUM_PINS-1:0] pin_oe,
  output logic                straps_valid,
  output logic                mode_strap,
  output logic                sdram_follow_cpu,
  output logic [FS_W-1:0]     fs_strap,
  output logic [FS_W-1:0]     freq_code,
  output logic                code_clamped
);
  logic   capture_now;
  logic   window_done;
  strap_t straps;

  strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
    .clk         (clk),
    .supply_ok   (supply_ok),
    .capture_now (capture_now),
    .window_done (window_done)
  );

  strap_capture u_cap (
    .clk         (clk),
    .supply_ok   (supply_ok),
    .capture_now (capture_now),
    .pins        (strap_pins),
    .straps      (straps)
  );

  freq_code_resolve #(.HIGH_PERF(HIGH_PERF), .SAFE_CODE(SAFE_CODE)) u_res (
    .clk        (clk),
    .supply_ok  (supply_ok),
    .use_reg    (reg_override),
    .reg_code   (reg_sel),
    .strap_code (straps.fs),
    .code       (freq_code),
    .clamped    (code_clamped)
  );

  // buffers enable one cycle after capture
  always_ff @(posedge clk) begin
    if (!supply_ok) pin_oe <= '0;
    else            pin_oe <= {NUM_PINS{window_done}};
  end

  assign straps_valid     = window_done;
  assign mode_strap       = straps.mode;
  assign sdram_follow_cpu = straps.sd_sel;
  assign fs_strap         = straps.fs;
endmodule

// File: rtl/strap_latch_ctrl_chk.sv
module strap_latch_ctrl_chk
  import strap_pkg::*;
#(
  parameter bit              HIGH_PERF = 1'b0,
  parameter logic [FS_W-1:0] SAFE_CODE = 3'b111
) (
  input logic                clk,
  input logic                supply_ok,
  input logic                reg_override,
  input logic [FS_W-1:0]     reg_sel,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic                straps_valid,
  input logic                mode_strap,
  input logic                sdram_follow_cpu,
  input logic [FS_W-1:0]     fs_strap,
  input logic [FS_W-1:0]     freq_code,
  input logic                code_clamped
);
  // R1
  supply_low_clears_chk: assert property (@(posedge clk)
    !supply_ok |=> (pin_oe == '0) && !straps_valid && (freq_code == '0));

  // R2
  closed_until_valid_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    !straps_valid |-> (pin_oe == '0));

  // R4
  enable_after_capture_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    $rose(straps_valid) |=> (pin_oe == '1));

  // R5
  straps_frozen_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    (straps_valid && $past(straps_valid)) |->
      ($stable(fs_strap) && $stable(mode_strap) && $stable(sdram_follow_cpu)));

  // R7
  override_path_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    ($past(supply_ok) && $past(reg_override) && ($past(reg_sel) != FAST_ONLY_CODE))
      |-> (freq_code == $past(reg_sel)));

  // R9
  clamp_value_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    code_clamped |-> (freq_code == SAFE_CODE) && !HIGH_PERF);

  // R10
  fast_code_legal_chk: assert property (@(posedge clk) disable iff (!supply_ok)
    (freq_code == FAST_ONLY_CODE) |-> (HIGH_PERF && !code_clamped));
endmodule

bind strap_latch_ctrl strap_latch_ctrl_chk #(
  .HIGH_PERF (HIGH_PERF),
  .SAFE_CODE (SAFE_CODE)
) u_chk (
  .clk              (clk),
  .supply_ok        (supply_ok),
  .reg_override     (reg_override),
  .reg_sel          (reg_sel),
  .pin_oe           (pin_oe),
  .straps_valid     (straps_valid),
  .mode_strap       (mode_strap),
  .sdram_follow_cpu (sdram_follow_cpu),
  .fs_strap         (fs_strap),
  .freq_code        (freq_code),
  .code_clamped     (code_clamped)
);

// File: tb/sim_strap_latch_ctrl.sv
`timescale 1ns/1ps
module sim_strap_latch_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WIN        = 8;

  logic       clk = 1'b0;
  logic       supply_ok = 1'b0;
  logic [4:0] pins = 5'b0;
  logic       ovr = 1'b0;
  logic [2:0] rsel = 3'b0;

  logic [4:0] oe0, oe1;
  logic       v0, v1, m0, m1, sd0, sd1, c0, c1;
  logic [2:0] fs0, fs1, fc0, fc1;

  int  vectors = 0;
  int  miscompares = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strap_latch_ctrl #(.WINDOW_CYCLES(WIN), .HIGH_PERF(1'b0), .SAFE_CODE(3'b111)) u0 (
    .clk(clk), .supply_ok(supply_ok), .strap_pins(pins), .reg_override(ovr),
    .reg_sel(rsel), .pin_oe(oe0), .straps_valid(v0), .mode_strap(m0),
    .sdram_follow_cpu(sd0), .fs_strap(fs0), .freq_code(fc0), .code_clamped(c0));

  strap_latch_ctrl #(.WINDOW_CYCLES(WIN), .HIGH_PERF(1'b1), .SAFE_CODE(3'b111)) u1 (
    .clk(clk), .supply_ok(supply_ok), .strap_pins(pins), .reg_override(ovr),
    .reg_sel(rsel), .pin_oe(oe1), .straps_valid(v1), .mode_strap(m1),
    .sdram_follow_cpu(sd1), .fs_strap(fs1), .freq_code(fc1), .code_clamped(c1));

  typedef struct {
    string      tag;
    bit         which;
    logic [14:0] exp;
  } item_t;

  item_t sb[$];

  function automatic logic [14:0] ev(logic [4:0] oe, logic v, logic m, logic sd,
                                     logic [2:0] fs, logic [2:0] fc, logic cl);
    return {oe, v, m, sd, fs, fc, cl};
  endfunction

  task automatic push(string tag, bit which, logic [14:0] exp);
    item_t it;
    it.tag = tag; it.which = which; it.exp = exp;
    sb.push_back(it);
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    while (sb.size() > 0) begin
      item_t it;
      logic [14:0] act;
      it  = sb.pop_front();
      act = it.which ? {oe1, v1, m1, sd1, fs1, fc1, c1}
                     : {oe0, v0, m0, sd0, fs0, fc0, c0};
      vectors++;
      if (act !== it.exp) begin
        miscompares++;
        $display("FAIL %s u%0d: actual %b expected %b", it.tag, it.which, act, it.exp);
      end
    end
  end

  task automatic finish_run();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (3000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    pins = 5'b10101; // sd_sel=1 mode=0 fs=101
    tick(3);
    push("R1 reset state", 0, ev(5'h00, 0, 0, 0, 3'b000, 3'b000, 0));

    supply_ok = 1'b1;
    tick(WIN - 1);
    push("R2 window still closed", 0, ev(5'h00, 0, 0, 0, 3'b000, 3'b000, 0));
    tick(1);
    push("R3 capture edge", 0, ev(5'h00, 1, 0, 1, 3'b101, 3'b000, 0));
    tick(1);
    push("R4 outputs enabled", 0, ev(5'h1f, 1, 0, 1, 3'b101, 3'b101, 0));
    push("R8 sdram follows cpu", 1, ev(5'h1f, 1, 0, 1, 3'b101, 3'b101, 0));

    pins = 5'b01010;
    tick(2);
    push("R5 pins ignored after capture", 0, ev(5'h1f, 1, 0, 1, 3'b101, 3'b101, 0));

    ovr = 1'b1; rsel = 3'b010;
    tick(1);
    push("R7 register override", 0, ev(5'h1f, 1, 0, 1, 3'b101, 3'b010, 0));

    rsel = 3'b110;
    tick(1);
    push("R9 fast code clamped", 0, ev(5'h1f, 1, 0, 1, 3'b101, 3'b111, 1));
    push("R10 fast code passes", 1, ev(5'h1f, 1, 0, 1, 3'b101, 3'b110, 0));

    ovr = 1'b0;
    tick(1);
    push("R7 strap path restored", 0, ev(5'h1f, 1, 0, 1, 3'b101, 3'b101, 0));

    supply_ok = 1'b0;
    tick(1);
    push("R6 power loss clears", 0, ev(5'h00, 0, 0, 0, 3'b000, 3'b000, 0));

    pins = 5'b01110; // sd_sel=0 mode=1 fs=110
    supply_ok = 1'b1;
    tick(4);
    supply_ok = 1'b0;
    tick(1);
    push("R6 drop mid window", 0, ev(5'h00, 0, 0, 0, 3'b000, 3'b000, 0));
    supply_ok = 1'b1;
    tick(WIN - 1);
    push("R6 window restarted", 0, ev(5'h00, 0, 0, 0, 3'b000, 3'b000, 0));

    ovr = 1'b1; rsel = 3'b001; // lands on capture edge
    tick(1);
    push("R7 override on capture edge", 0, ev(5'h00, 1, 1, 0, 3'b110, 3'b001, 0));
    push("R7 override on capture edge", 1, ev(5'h00, 1, 1, 0, 3'b110, 3'b001, 0));
    tick(1);
    push("R8 sdram follows agp", 0, ev(5'h1f, 1, 1, 0, 3'b110, 3'b001, 0));

    ovr = 1'b0;
    tick(1);
    push("R9 strap code clamped", 0, ev(5'h1f, 1, 1, 0, 3'b110, 3'b111, 1));
    push("R10 strap fast code", 1, ev(5'h1f, 1, 1, 0, 3'b110, 3'b110, 0));

    tick(2);
    finish_run();
  end
endmodule